// File: doc/BRIEF.md
# In-Band Repeating Code Monitor

This block watches a received serial bit stream for two short repeating patterns simultaneously. One is an activate (loop-up) code and one is a deactivate (loop-down) code. Each detector has its own pattern and its own length setting of 4, 5, 6 or 7 bits. A code shorter than four bits is handled by entering it repeated, so a 3-bit code `001` is entered as the 6-bit pattern `001001`. Any pattern that repeats with a period of 1 to 7 bits can therefore be watched. The typical line codes are `00001` for activate and `001` for deactivate.

Bits are taken only on cycles where the bit strobe is high. Every L accepted bits, where L is the length that detector is set to, closes one period. A period counts as matching when its last L bits are some rotation of the pattern and also equal the L bits that came just before them. A detector declares its code present after a run of consecutive matching periods, and withdraws it after a run of the same length of non-matching periods. The run length is the parameter `REPS`, which defaults to 16. On detection the block raises a level status and a sticky status bit. The sticky bits, gated by per-code enables, form a single interrupt request. The block never switches any loopback itself. Logic outside the block must act on the status.

Top module: `inband_loop_monitor`

## Requirements
- R1: While reset is held and right after it is released, both level outputs, both sticky bits and the interrupt request are 0.
- R2: Suppose the stream repeats the activate pattern from a cleared history. Then `up_lvl` is 0 after (REPS+1)*L−1 accepted bits and is 1 after (REPS+1)*L accepted bits. The first period cannot match, because the bits in front of it are zeros. The level rises at the edge that takes the last bit of the REPS-th matching period.
- R3: The length code works as L = 4 + code, giving 4, 5, 6 or 7. Pattern bit L−1 is the first bit received and bit 0 is the last. Pattern bits above L−1 have no effect.
- R4: The two detectors run independently on the same stream. Each has its own pattern, length, period phase and counters.
- R5: A 3-bit code such as `001` is detected when it is entered as `001001` with length 6.
- R6: Once a code is detected, its level stays 1 until REPS consecutive non-matching periods have closed. It drops to 0 at the edge that closes the last of those periods.
- R7: A sticky bit is set at the edge where its level rises. It is not set when the level falls. It stays set until a clear strobe arrives in a cycle with no new rise. If a rise and a clear fall in the same cycle, the set wins. A clear does not change the level.
- R8: `irq` is 1 exactly when some sticky bit is set and its enable is 1. Changing an enable affects `irq` in the same cycle.
- R9: A cycle with `rx_en` low takes no bit. The bit count, the period phase and the levels do not move, so gaps between bits do not change when detection happens.
- R10: A change to a detector's pattern (in the used bits) or its length clears that detector's period phase and its match counters. Counting then restarts from the next accepted bit.
- R11: The pattern is found at any rotation. A stream that starts at any of the L rotations is detected after the same number of bits.
- R12: One non-matching period before the run is complete restarts the count of matching periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_bit | input | 1 | Received data bit |
| rx_en | input | 1 | Bit strobe; rx_bit is taken when high |
| up_pat | input | 7 | Activate pattern, bit L−1 first received |
| up_len | input | 2 | Activate length code (L = 4 + code) |
| dn_pat | input | 7 | Deactivate pattern, bit L−1 first received |
| dn_len | input | 2 | Deactivate length code (L = 4 + code) |
| up_ie | input | 1 | Interrupt enable for activate sticky bit |
| dn_ie | input | 1 | Interrupt enable for deactivate sticky bit |
| up_clr | input | 1 | Clear strobe for activate sticky bit |
| dn_clr | input | 1 | Clear strobe for deactivate sticky bit |
| up_lvl | output | 1 | Activate code currently detected |
| dn_lvl | output | 1 | Deactivate code currently detected |
| up_sticky | output | 1 | Activate detection event latched |
| dn_sticky | output | 1 | Deactivate detection event latched |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with REPS set to 4. At that setting a detection finishes within 35 accepted bits even at length 7. This makes it affordable to sweep every length and every starting rotation of the stream, once with back-to-back bits and once with idle cycles between bits. At each point the bench checks the exact bit count at which the level rises. The short run also lets the bench cover the full set, clear and release sequence of the sticky and interrupt path, a broken run, a mid-stream pattern change, and both detectors working on one stream, each within a few dozen bits.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int MAX_LEN = 7;
  localparam int HIST_W  = 2 * MAX_LEN;

  typedef logic [MAX_LEN-1:0] pat_t;

  // Length code to period length in bits: 4..7.
  function automatic logic [2:0] len_of(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

  // Mask covering the low len bits of a pattern.
  function automatic pat_t mask_of(input logic [2:0] len);
    return pat_t'(7'h7f >> (3'd7 - len));
  endfunction
endpackage

// File: rtl/lbc_history.sv
module lbc_history
  import lbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] win_next
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  // Newest bit lands in position 0.
  assign win_next = {hist_q[HIST_W-2:0], bit_in};

  always_comb begin
    hist_d = hist_q;
    if (en) hist_d = win_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/lbc_detector.sv
module lbc_detector
  import lbc_pkg::*;
#(
  parameter int REPS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HIST_W-1:0] win,
  input  pat_t              pat,
  input  logic [1:0]        len_code,
  output logic              det,
  output logic              rise
);
  localparam int CW = $clog2(REPS + 1);
  localparam logic [CW-1:0] LAST = CW'(REPS - 1);

  logic [2:0]        len;
  pat_t              mask;
  pat_t              p_used;
  pat_t              win_lo;
  logic [HIST_W-1:0] pp;
  logic              hit;
  logic              periodic;
  logic              ok;
  logic              cfg_chg;
  logic              end_per;

  logic [2:0]    ph_q,  ph_d;
  logic [CW-1:0] mc_q,  mc_d;
  logic [CW-1:0] xc_q,  xc_d;
  logic          det_q, det_d;
  pat_t          pat_q;
  logic [1:0]    len_q;

  assign len    = len_of(len_code);
  assign mask   = mask_of(len);
  assign p_used = pat & mask;
  assign win_lo = win[MAX_LEN-1:0] & mask;
  assign pp     = {{MAX_LEN{1'b0}}, p_used} | ({{MAX_LEN{1'b0}}, p_used} << len);

  // Window equals some rotation of the pattern.
  always_comb begin
    logic [HIST_W-1:0] sh;
    hit = 1'b0;
    for (int r = 0; r < MAX_LEN; r++) begin
      sh = pp >> r;
      if (r < int'(len) && ((sh[MAX_LEN-1:0] & mask) == win_lo)) hit = 1'b1;
    end
  end

  // Window equals the period before it.
  always_comb begin
    logic [HIST_W-1:0] prev;
    prev     = win >> len;
    periodic = ((prev[MAX_LEN-1:0] & mask) == win_lo);
  end

  assign ok      = hit & periodic;
  assign cfg_chg = (p_used != pat_q) || (len_code != len_q);
  assign end_per = en && (ph_q == len - 3'd1);

  always_comb begin
    ph_d  = ph_q;
    mc_d  = mc_q;
    xc_d  = xc_q;
    det_d = det_q;
    if (cfg_chg) begin
      ph_d = '0;
      mc_d = '0;
      xc_d = '0;
    end else if (en) begin
      ph_d = end_per ? 3'd0 : ph_q + 3'd1;
      if (end_per) begin
        if (!det_q) begin
          if (!ok)              mc_d = '0;
          else if (mc_q == LAST) begin
            det_d = 1'b1;
            mc_d  = '0;
          end else              mc_d = mc_q + 1'b1;
        end else begin
          if (ok)               xc_d = '0;
          else if (xc_q == LAST) begin
            det_d = 1'b0;
            xc_d  = '0;
          end else              xc_d = xc_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      mc_q  <= '0;
      xc_q  <= '0;
      det_q <= 1'b0;
      pat_q <= '0;
      len_q <= '0;
    end else begin
      ph_q  <= ph_d;
      mc_q  <= mc_d;
      xc_q  <= xc_d;
      det_q <= det_d;
      pat_q <= p_used;
      len_q <= len_code;
    end
  end

  assign det  = det_q;
  assign rise = det_d & ~det_q;
endmodule

// File: rtl/inband_loop_monitor.sv
module inband_loop_monitor
  import lbc_pkg::*;
#(
  parameter int REPS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_bit,
  input  logic               rx_en,
  input  logic [MAX_LEN-1:0] up_pat,
  input  logic [1:0]         up_len,
  input  logic [MAX_LEN-1:0] dn_pat,
  input  logic [1:0]         dn_len,
  input  logic               up_ie,
  input  logic               dn_ie,
  input  logic               up_clr,
  input  logic               dn_clr,
  output logic               up_lvl,
  output logic               dn_lvl,
  output logic               up_sticky,
  output logic               dn_sticky,
  output logic               irq
);
  localparam int NDET = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [HIST_W-1:0] win;
  pat_t              pat_a [NDET];
  logic [1:0]        len_a [NDET];
  logic [NDET-1:0]   det_a, rise_a;
  logic [NDET-1:0]   stk_q, stk_d, clr_v, ie_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lbc_history u_hist (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (rx_en),
    .bit_in   (rx_bit),
    .win_next (win)
  );

  assign pat_a[0] = up_pat;
  assign pat_a[1] = dn_pat;
  assign len_a[0] = up_len;
  assign len_a[1] = dn_len;

  for (genvar g = 0; g < NDET; g++) begin : g_det
    lbc_detector #(.REPS(REPS)) u_det (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .en       (rx_en),
      .win      (win),
      .pat      (pat_a[g]),
      .len_code (len_a[g]),
      .det      (det_a[g]),
      .rise     (rise_a[g])
    );
  end

  assign clr_v = {dn_clr, up_clr};
  assign ie_v  = {dn_ie, up_ie};
  assign stk_d = (stk_q & ~clr_v) | rise_a;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) stk_q <= '0;
    else            stk_q <= stk_d;
  end

  assign up_lvl    = det_a[0];
  assign dn_lvl    = det_a[1];
  assign up_sticky = stk_q[0];
  assign dn_sticky = stk_q[1];
  assign irq       = |(stk_q & ie_v);
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic up_lvl,
  input logic dn_lvl,
  input logic up_sticky,
  input logic dn_sticky,
  input logic up_clr,
  input logic dn_clr,
  input logic up_ie,
  input logic dn_ie,
  input logic irq
);
  // R7
  up_sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_lvl) |-> up_sticky);
  // R7
  dn_sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_lvl) |-> dn_sticky);
  // R7
  up_sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_sticky && !up_clr |=> up_sticky);
  // R7
  dn_sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_sticky && !dn_clr |=> dn_sticky);
  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (up_sticky || dn_sticky));
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_ie && !dn_ie) |-> !irq);
  // R9
  up_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(up_lvl));
  // R9
  dn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(dn_lvl));
endmodule

bind inband_loop_monitor lbc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .up_lvl    (up_lvl),
  .dn_lvl    (dn_lvl),
  .up_sticky (up_sticky),
  .dn_sticky (dn_sticky),
  .up_clr    (up_clr),
  .dn_clr    (dn_clr),
  .up_ie     (up_ie),
  .dn_ie     (dn_ie),
  .irq       (irq)
);

// File: tb/tb_inband_loop_monitor.sv
module tb_inband_loop_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int REPS       = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_bit, rx_en;
  logic [6:0] up_pat, dn_pat;
  logic [1:0] up_len, dn_len;
  logic       up_ie, dn_ie, up_clr, dn_clr;
  logic       up_lvl, dn_lvl, up_sticky, dn_sticky, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inband_loop_monitor #(.REPS(REPS)) dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en(rx_en),
    .up_pat(up_pat), .up_len(up_len), .dn_pat(dn_pat), .dn_len(dn_len),
    .up_ie(up_ie), .dn_ie(dn_ie), .up_clr(up_clr), .dn_clr(dn_clr),
    .up_lvl(up_lvl), .dn_lvl(dn_lvl), .up_sticky(up_sticky),
    .dn_sticky(dn_sticky), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bit k of a stream repeating pattern p (length L) started at rotation r.
  function automatic logic sbit(input logic [6:0] p, input int L, input int r, input int k);
    return p[L - 1 - ((k + r) % L)];
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0; rx_en = 1'b0; rx_bit = 1'b0; up_clr = 1'b0; dn_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b; rx_en = 1'b1;
    @(posedge clk);
    #1 rx_en = 1'b0;
  endtask

  task automatic send_bit_clr(input logic b);
    @(negedge clk);
    rx_bit = b; rx_en = 1'b1; up_clr = 1'b1;
    @(posedge clk);
    #1 rx_en = 1'b0; up_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sweep_case(input int L, input int r);
    logic [6:0] m, p;
    int n;
    bit gap;
    m = 7'h7f >> (7 - L);
    p = (r % 2 == 0) ? 7'd1 : 7'd3;
    gap = (r == 1);
    up_len = 2'(L - 4); up_pat = p | ~m;       // R3: upper bits set, must be ignored
    dn_len = 2'd0; dn_pat = 7'h55;
    up_ie = 1'b0; dn_ie = 1'b0;
    apply_reset();
    n = (REPS + 1) * L;
    for (int k = 0; k < n - 1; k++) begin
      send_bit(sbit(p, L, r, k));
      if (gap) idle(1);                          // R9 gaps
    end
    chk($sformatf("R2/R9 early L=%0d r=%0d", L, r), 32'(up_lvl), 0);
    send_bit(sbit(p, L, r, n - 1));
    chk($sformatf("R2/R3/R11 detect L=%0d r=%0d", L, r), 32'(up_lvl), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] p, prot;
    int L;

    // R1: reset state
    up_pat = 7'd1; up_len = 2'd1; dn_pat = 7'd9; dn_len = 2'd2;
    up_ie = 1'b1; dn_ie = 1'b1;
    apply_reset();
    chk("R1 up_lvl", 32'(up_lvl), 0);
    chk("R1 dn_lvl", 32'(dn_lvl), 0);
    chk("R1 up_sticky", 32'(up_sticky), 0);
    chk("R1 dn_sticky", 32'(dn_sticky), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2, R3, R9, R11: all lengths, all rotations
    for (int l = 4; l <= 7; l++)
      for (int r = 0; r < l; r++)
        sweep_case(l, r);

    // R7, R8, R6: sticky, interrupt and release
    L = 5; p = 7'b0000001;
    up_len = 2'd1; up_pat = p; dn_len = 2'd0; dn_pat = 7'h55;
    up_ie = 1'b0; dn_ie = 1'b0;
    apply_reset();
    for (int k = 0; k < (REPS + 1) * L - 1; k++) send_bit(sbit(p, L, 0, k));
    send_bit_clr(sbit(p, L, 0, (REPS + 1) * L - 1));
    chk("R7 set wins over clear", 32'(up_sticky), 1);
    chk("R8 irq masked", 32'(irq), 0);
    @(negedge clk) up_ie = 1'b1;
    #1 chk("R8 irq enabled", 32'(irq), 1);
    @(negedge clk) up_clr = 1'b1;
    @(posedge clk) #1 up_clr = 1'b0;
    chk("R7 sticky cleared", 32'(up_sticky), 0);
    chk("R8 irq after clear", 32'(irq), 0);
    chk("R7 level kept after clear", 32'(up_lvl), 1);
    for (int k = 0; k < REPS * L - 1; k++) send_bit(1'b1);
    chk("R6 level held", 32'(up_lvl), 1);
    send_bit(1'b1);
    chk("R6 level released", 32'(up_lvl), 0);
    chk("R7 no set on release", 32'(up_sticky), 0);
    up_ie = 1'b0;

    // R12: a broken period restarts the run
    L = 4; p = 7'b0000001;
    up_len = 2'd0; up_pat = p;
    apply_reset();
    for (int k = 0; k < 2 * L; k++) send_bit(sbit(p, L, 0, k));
    for (int k = 0; k < L; k++) send_bit(1'b1);
    for (int k = 0; k < (REPS + 1) * L - 1; k++) send_bit(sbit(p, L, 0, k));
    chk("R12 restarted run not yet done", 32'(up_lvl), 0);
    send_bit(sbit(p, L, 0, (REPS + 1) * L - 1));
    chk("R12 detect after restart", 32'(up_lvl), 1);

    // R10: pattern change restarts counting
    L = 6; p = 7'b0000011;
    up_len = 2'd2; up_pat = p;
    apply_reset();
    for (int k = 0; k < 3 * L; k++) send_bit(sbit(p, L, 0, k));
    prot = ((p << 1) | (p >> (L - 1))) & (7'h7f >> (7 - L));
    @(negedge clk) up_pat = prot;
    idle(2);
    for (int k = 3 * L; k < 3 * L + REPS * L - 1; k++) send_bit(sbit(p, L, 0, k));
    chk("R10 count restarted", 32'(up_lvl), 0);
    send_bit(sbit(p, L, 0, 3 * L + REPS * L - 1));
    chk("R10 detect after change", 32'(up_lvl), 1);

    // R4, R5: both detectors on one stream, short code by repetition
    up_len = 2'd1; up_pat = 7'b0000001;
    dn_len = 2'd2; dn_pat = 7'b0001001;
    apply_reset();
    for (int k = 0; k < 29; k++) send_bit(k % 3 == 2);
    chk("R5 short code not yet", 32'(dn_lvl), 0);
    send_bit(1'b1);
    chk("R5 short code detected", 32'(dn_lvl), 1);
    chk("R4 activate idle on other code", 32'(up_lvl), 0);
    for (int k = 0; k < 30; k++) send_bit(k % 5 == 4);
    chk("R4 activate detected", 32'(up_lvl), 1);
    chk("R4 deactivate released", 32'(dn_lvl), 0);
    chk("R4 both sticky", 32'({up_sticky, dn_sticky}), 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule